// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between a CPU's 16-bit address bus and a cartridge's ROM and RAM arrays. Writes that land in the read-only ROM window never reach the ROM. The block decodes them as control writes instead. They select which 16 KiB ROM page appears in the upper ROM window and which 8 KiB RAM page appears in the external RAM window. They also open or close that RAM window. Reads are translated into physical ROM or RAM addresses together with enable flags. The arrays themselves sit outside the block.

A parameter picks the width of the ROM page field: 5 bits for the narrow variant and 7 bits for the wide one. The cartridge's ROM size and RAM page count arrive as inputs. The ROM size is given in 32 KiB units. A page number is masked to that size, and a page of zero is promoted to one. A RAM page that the cartridge lacks is refused. A mode latch is held for a banking extension, and setting it is refused on large ROMs.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write to 0x0000-0x1FFF sets `ramOn` when data bits [3:0] equal 0xA and clears it for any other value; the upper nibble has no effect.
- R2: A write to 0x2000-0x3FFF takes the ROM page from data bits [4:0] (narrow variant, default) or [6:0] (wide variant); higher data bits are dropped.
- R3: The written page is ANDed with (2 × `romBankCount` − 1); if the result is zero, page 1 is stored instead.
- R4: A write to 0x4000-0x5FFF takes data bits [1:0] as the RAM page, and is discarded when that value is not below `ramBankCount`.
- R5: A read in 0x0000-0x3FFF always drives `romAddr` equal to the CPU address, whatever the ROM page, with `romRdEn` high.
- R6: A read in 0x4000-0x7FFF drives `romAddr` = page × 0x4000 + address[13:0]; when the page is not below 2 × `romBankCount`, `romRdEn` stays low and the read returns 0x00.
- R7: A write to 0x6000-0x7FFF loads data bit 0 into `altMode`; a write of 1 is ignored when `romBankCount` exceeds 32, while a write of 0 is always taken.
- R8: A read or write in 0xA000-0xBFFF drives `ramAddr` = RAM page × 0x2000 + address[12:0]; `ramRdEn`/`ramWrEn` assert only while `ramOn` is set, so a read of a closed RAM returns 0xFF and a write is blocked.
- R9: After reset `ramOn` and `altMode` are 0, the ROM page is 1 and the RAM page is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| romBankCount | input | 8 | ROM size in 32 KiB units |
| ramBankCount | input | 3 | Number of 8 KiB RAM pages present |
| romAddr | output | 19 | Physical ROM byte address (page width + 14 bits) |
| romRdEn | output | 1 | ROM read enable for an in-range ROM read |
| ramAddr | output | 15 | Physical RAM byte address |
| ramRdEn | output | 1 | RAM read enable |
| ramWrEn | output | 1 | RAM write enable |
| ramOn | output | 1 | External RAM open |
| altMode | output | 1 | Banking mode latch |

## Verification
The RAM page register sits at 0x4000-0x5FFF, which is also the lower half of the banked ROM read window. A read strobe and a RAM page write can therefore be driven together at one address. The bench raises both strobes at 0x4123 and checks, before the clock edge, that the ROM address still comes from the current ROM page and that no RAM write is enabled. After the edge, it probes the RAM window to confirm that the new RAM page took effect while the ROM page stayed as it was.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  typedef struct packed {
    logic ldRamOn;    // enable key register
    logic ldRomBank;  // ROM page register
    logic ldRamBank;  // RAM page register
    logic ldMode;     // mode latch
    logic romLo;      // read of the fixed ROM window
    logic romHi;      // read of the switched ROM window
    logic ramRd;      // read of the external RAM window
    logic ramWr;      // write of the external RAM window
  } ctrl_strobe_t;
endpackage

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
(
  input  logic [15:0]  cpuAddr,
  input  logic         cpuWr,
  input  logic         cpuRd,
  output ctrl_strobe_t strobes
);
  logic [2:0] region;
  assign region = cpuAddr[15:13];

  always_comb begin
    strobes = '0;
    strobes.ldRamOn   = cpuWr && (region == 3'd0);
    strobes.ldRomBank = cpuWr && (region == 3'd1);
    strobes.ldRamBank = cpuWr && (region == 3'd2);
    strobes.ldMode    = cpuWr && (region == 3'd3);
    strobes.romLo     = cpuRd && (cpuAddr[15:14] == 2'b00);
    strobes.romHi     = cpuRd && (cpuAddr[15:14] == 2'b01);
    strobes.ramRd     = cpuRd && (region == 3'd5);
    strobes.ramWr     = cpuWr && (region == 3'd5);
  end
endmodule

// File: rtl/cart_bank_datapath.sv
module cart_bank_datapath
  import cart_bank_pkg::*;
#(
  parameter int BANK_W    = 5,
  parameter int RAM_SEL_W = 2,
  parameter int CNT_W     = 8,
  parameter int RCNT_W    = 3,
  localparam int ROM_AW   = BANK_W + 14,
  localparam int RAM_AW   = RAM_SEL_W + 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        wrData,
  input  logic [CNT_W-1:0]  romBankCount,
  input  logic [RCNT_W-1:0] ramBankCount,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romRdEn,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic              ramOn,
  output logic              altMode
);
  localparam int SZ_W = CNT_W + 1;

  logic [BANK_W-1:0]    romBank, rawField, maskedField, nextRomBank;
  logic [RAM_SEL_W-1:0] ramBank;
  logic [SZ_W-1:0]      romPages, pageMask, bankWide;
  logic                 ramSelOk, modeOk, inRange;

  assign romPages    = {romBankCount, 1'b0};
  assign pageMask    = romPages - SZ_W'(1);
  assign rawField    = wrData[BANK_W-1:0];
  assign maskedField = rawField & pageMask[BANK_W-1:0];
  assign nextRomBank = (maskedField == '0) ? BANK_W'(1) : maskedField;
  assign ramSelOk    = RCNT_W'(wrData[RAM_SEL_W-1:0]) < ramBankCount;
  assign modeOk      = !wrData[0] || (romBankCount <= CNT_W'(32));
  assign bankWide    = SZ_W'(romBank);
  assign inRange     = bankWide < romPages;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramOn   <= 1'b0;
      romBank <= BANK_W'(1);
      ramBank <= '0;
      altMode <= 1'b0;
    end else begin
      if (strobes.ldRamOn)   ramOn   <= (wrData[3:0] == 4'hA);
      if (strobes.ldRomBank) romBank <= nextRomBank;
      if (strobes.ldRamBank && ramSelOk) ramBank <= wrData[RAM_SEL_W-1:0];
      if (strobes.ldMode && modeOk) altMode <= wrData[0];
    end
  end

  always_comb begin
    if (cpuAddr[14]) romAddr = {romBank, cpuAddr[13:0]};
    else             romAddr = {{BANK_W{1'b0}}, cpuAddr[13:0]};
  end
  assign romRdEn = strobes.romLo || (strobes.romHi && inRange);
  assign ramAddr = {ramBank, cpuAddr[12:0]};
  assign ramRdEn = strobes.ramRd && ramOn;
  assign ramWrEn = strobes.ramWr && ramOn;

  assert_enable_key_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ldRamOn |=> (ramOn == ($past(wrData[3:0]) == 4'hA)));

  assert_bank_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    romBank != '0);

  assert_rambank_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldRamBank && (RCNT_W'(wrData[RAM_SEL_W-1:0]) >= ramBankCount)) |=> $stable(ramBank));

  assert_lo_fixed_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.romLo |-> (romRdEn && (romAddr[ROM_AW-1:14] == '0)));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldMode && wrData[0] && (romBankCount > CNT_W'(32))) |=> $stable(altMode));

  assert_ram_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ramRdEn || ramWrEn) |-> ramOn);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_bank_pkg::*;
#(
  parameter bit WIDE_ROM_FIELD = 1'b0,
  localparam int BANK_W = WIDE_ROM_FIELD ? 7 : 5,
  localparam int ROM_AW = BANK_W + 14,
  localparam int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [7:0]        romBankCount,
  input  logic [2:0]        ramBankCount,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romRdEn,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  output logic              ramOn,
  output logic              altMode
);
  ctrl_strobe_t strobes;

  cart_bank_ctrl uCtrl (
    .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuRd(cpuRd), .strobes(strobes)
  );

  cart_bank_datapath #(
    .BANK_W(BANK_W), .RAM_SEL_W(RAM_AW - 13), .CNT_W(8), .RCNT_W(3)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr),
    .wrData(cpuWrData), .romBankCount(romBankCount), .ramBankCount(ramBankCount),
    .romAddr(romAddr), .romRdEn(romRdEn), .ramAddr(ramAddr),
    .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .ramOn(ramOn), .altMode(altMode)
  );
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0]  romBankCount = 8'd16;
  logic [2:0]  ramBankCount = 3'd4;
  logic [18:0] romAddr;
  logic [14:0] ramAddr;
  logic        romRdEn, ramRdEn, ramWrEn, ramOn, altMode;

  int nChecks = 0, nFails = 0;
  logic [7:0] ramModel [int];

  always #10 clk = ~clk;

  cart_bank_mapper dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .romBankCount(romBankCount),
    .ramBankCount(ramBankCount), .romAddr(romAddr), .romRdEn(romRdEn),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn),
    .ramOn(ramOn), .altMode(altMode)
  );

  // {write data, ROM size in 32 KiB units, expected page} for the narrow variant
  localparam logic [22:0] VEC [12] = '{
    {8'h00, 8'd16, 7'd1},  {8'h01, 8'd16, 7'd1},  {8'h1F, 8'd16, 7'd31},
    {8'h20, 8'd16, 7'd1},  {8'h25, 8'd16, 7'd5},  {8'h13, 8'd4,  7'd3},
    {8'h08, 8'd4,  7'd1},  {8'h0F, 8'd2,  7'd3},  {8'hFF, 8'd1,  7'd1},
    {8'h1E, 8'd1,  7'd1},  {8'h16, 8'd8,  7'd6},  {8'h3A, 8'd64, 7'd26}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1; cpuRd = 1'b0;
    @(posedge clk); #1 cpuWr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1; cpuWr = 1'b0;
    #5;
  endtask

  task automatic ramWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1; cpuRd = 1'b0;
    #5 if (ramWrEn) ramModel[int'(ramAddr)] = d;
    @(posedge clk); #1 cpuWr = 1'b0;
  endtask

  function automatic logic [7:0] ramData();
    if (!ramRdEn) return 8'hFF;
    if (ramModel.exists(int'(ramAddr))) return ramModel[int'(ramAddr)];
    return 8'h00;
  endfunction

  initial begin
    #4_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9 reset state
    probe(16'h4000);
    chk("R9 rom page after reset", romAddr, 19'h04000);
    chk("R9 romRdEn", romRdEn, 1);
    probe(16'hA000);
    chk("R9 ram page after reset", ramAddr, 15'h0000);
    chk("R9 ramOn", ramOn, 0);
    chk("R9 altMode", altMode, 0);
    chk("R9 closed ram read", ramRdEn, 0);

    // R2 R3 R6 vector table
    for (int i = 0; i < 12; i++) begin
      romBankCount = VEC[i][14:7];
      wrReg(16'h2000 + 16'(i * 16'h0111), VEC[i][22:15]);
      probe(16'h5ABC);
      chk("R3 R2 mapped page", romAddr, {VEC[i][6:0], 14'h0000} + 19'h1ABC);
      chk("R6 romRdEn", romRdEn, 1);
    end

    // R5 fixed lower window ignores the page
    romBankCount = 8'd16;
    wrReg(16'h3FFF, 8'h07);
    probe(16'h3FFF);
    chk("R5 fixed window top", romAddr, 19'h03FFF);
    chk("R5 romRdEn", romRdEn, 1);
    probe(16'h0000);
    chk("R5 fixed window base", romAddr, 19'h00000);

    // R6 beyond ROM size
    wrReg(16'h2000, 8'h14);
    probe(16'h4000);
    chk("R6 page 20 address", romAddr, 19'h50000);
    chk("R6 page 20 in range", romRdEn, 1);
    romBankCount = 8'd4;
    probe(16'h4000);
    chk("R6 beyond size no read (data 0x00)", romRdEn, 0);
    romBankCount = 8'd16;

    // R1 enable key
    wrReg(16'h1000, 8'h0A); probe(16'hA000); chk("R1 0x0A opens", ramOn, 1);
    wrReg(16'h0000, 8'h0B); probe(16'hA000); chk("R1 0x0B closes", ramOn, 0);
    wrReg(16'h1FFF, 8'hFA); probe(16'hA000); chk("R1 0xFA opens", ramOn, 1);
    wrReg(16'h0800, 8'hA0); probe(16'hA000); chk("R1 0xA0 closes", ramOn, 0);
    wrReg(16'h0001, 8'h3A); probe(16'hA000); chk("R1 0x3A opens", ramOn, 1);

    // R8 RAM mapping and gating
    wrReg(16'h4000, 8'h02);
    probe(16'hA123);
    chk("R8 ram address page 2", ramAddr, 15'h4123);
    chk("R8 ramRdEn open", ramRdEn, 1);
    ramWrite(16'hA123, 8'h5C);
    probe(16'hA123);
    chk("R8 readback", ramData(), 8'h5C);
    wrReg(16'h0000, 8'h00);
    @(negedge clk);
    cpuAddr = 16'hA123; cpuWrData = 8'h77; cpuWr = 1'b1; cpuRd = 1'b0;
    #5 chk("R8 closed write blocked", ramWrEn, 0);
    if (ramWrEn) ramModel[int'(ramAddr)] = 8'h77;
    @(posedge clk); #1 cpuWr = 1'b0;
    probe(16'hA123);
    chk("R8 closed read 0xFF", ramData(), 8'hFF);
    wrReg(16'h0000, 8'h0A);
    probe(16'hA123);
    chk("R8 data kept", ramData(), 8'h5C);

    // R4 RAM page range
    ramBankCount = 3'd2;
    wrReg(16'h5000, 8'h03);
    probe(16'hA000);
    chk("R4 out of range discarded", ramAddr, 15'h4000);
    wrReg(16'h5FFF, 8'hFD);
    probe(16'hA000);
    chk("R4 low bits taken", ramAddr, 15'h2000);

    // R7 mode latch
    romBankCount = 8'd64;
    wrReg(16'h6000, 8'h01); probe(16'h0000); chk("R7 set refused large rom", altMode, 0);
    romBankCount = 8'd32;
    wrReg(16'h7000, 8'h01); probe(16'h0000); chk("R7 set accepted", altMode, 1);
    romBankCount = 8'd64;
    wrReg(16'h7FFF, 8'h00); probe(16'h0000); chk("R7 clear accepted", altMode, 0);
    romBankCount = 8'd16;

    // Same cycle: RAM page write with a banked ROM read at one address (R4 R6)
    ramBankCount = 3'd4;
    wrReg(16'h2000, 8'h03);
    @(negedge clk);
    cpuAddr = 16'h4123; cpuWrData = 8'h02; cpuWr = 1'b1; cpuRd = 1'b1;
    #5;
    chk("R6 read during page write", romAddr, 19'h0C123);
    chk("R6 romRdEn during page write", romRdEn, 1);
    chk("R8 no ram write from register write", ramWrEn, 0);
    @(posedge clk); #1 cpuWr = 1'b0; cpuRd = 1'b0;
    probe(16'hA000);
    chk("R4 page taken in shared cycle", ramAddr, 15'h4000);
    probe(16'h4000);
    chk("R6 rom page unchanged", romAddr, 19'h0C000);

    // R9 reset in mid run
    @(negedge clk); cpuRd = 1'b0; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    probe(16'h4000);
    chk("R9 page back to 1", romAddr, 19'h04000);
    probe(16'hA000);
    chk("R9 ram closed", ramOn, 0);
    chk("R9 ram page 0", ramAddr, 15'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule